// File: doc/BRIEF.md
# Dual-Channel Conversion Sequencer

This block schedules conversions for a measurement front end that has two channels sharing one converter: a capacitive channel and a voltage/temperature channel. A three-bit operating mode, one enable per channel, a rate code per channel, a chopping flag for the capacitive channel and a clock-halving flag decide which channel converts next and for how long. The block issues a start strobe with a channel select, times the conversion with a prescaled 0.1 ms tick counter, and copies the 24-bit result of the converter model into that channel's data register when the conversion completes.

It also keeps the status byte and an active-low ready pin for the host interface. The host interface reports two things per channel: a busy level while a bus read of that channel's data register is in progress, and a done pulse when such a read ends. A result that completes while its register is busy is discarded, not queued. In single-shot mode, the block raises a one-cycle done pulse so that the register file can put the mode field back to idle.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the status byte is 0x07, the ready pin is high, both data registers are zero and no start strobe is issued.
- R2: Mode codes other than 001 (continuous) and 010 (single) never issue a start. This covers idle 000, power-down 011, calibration 101/110 and the unused codes.
- R3: A capacitive conversion lasts U x TPU clock cycles, where TPU is the ticks-per-0.1-ms parameter. With chopping off, U for rate codes 0..7 is 110, 119, 200, 380, 620, 770, 920, 1096. With chopping on, U is 201, 220, 381, 741, 1221, 1521, 1821, 2173. The clock-halving flag doubles U. In continuous mode, consecutive start strobes are therefore U x TPU + 1 cycles apart.
- R4: A voltage/temperature conversion lasts U x TPU cycles with U = 201, 321, 621, 1221 for rate codes 0..3, doubled by the clock-halving flag.
- R5: Continuous mode alternates capacitive (select 0) and voltage/temperature (select 1) when both are enabled, and repeats the single enabled channel otherwise.
- R6: Single mode converts the capacitive channel and then the voltage/temperature channel (each only if enabled), pulses single_done_o, and starts nothing more until the mode leaves 010.
- R7: On completion the result is copied into that channel's data register, and the channel's ready bit (status bit 0 capacitive, bit 1 voltage/temperature) goes to 0.
- R8: The combined ready bit (status bit 2) mirrors the single enabled channel. With both enabled, it falls only when the voltage/temperature conversion completes while a fresh, unread capacitive result is held.
- R9: A ready bit returns to 1 when the read-done pulse for its channel arrives, and one cycle before the next completion of its channel. The combined bit rises on any read-done pulse and at every conversion's final cycle.
- R10: A result that completes while its channel's read-busy input is high is discarded: the data register keeps its old value and the channel's ready bit stays 1.
- R11: rdy_n_o always equals status bit 2.
- R12: Moving the mode out of 001/010 during a conversion aborts it with no data or status update.
- R13: Status bit 3 follows the excitation-error input, and bits 7..4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode code |
| cap_en_i | input | 1 | Capacitive channel enable |
| vt_en_i | input | 1 | Voltage/temperature channel enable |
| cap_rate_i | input | 3 | Capacitive rate code |
| cap_chop_i | input | 1 | Capacitive chopping on |
| vt_rate_i | input | 2 | Voltage/temperature rate code |
| clk_div_i | input | 1 | Doubles all conversion times |
| exc_err_i | input | 1 | Excitation error flag from the analog side |
| cap_result_i | input | DATA_W | Capacitive result from converter model |
| vt_result_i | input | DATA_W | Voltage/temperature result from converter model |
| cap_rd_busy_i | input | 1 | Bus read of capacitive data in progress |
| vt_rd_busy_i | input | 1 | Bus read of voltage/temperature data in progress |
| cap_rd_done_i | input | 1 | Pulse: capacitive data read ended |
| vt_rd_done_i | input | 1 | Pulse: voltage/temperature data read ended |
| conv_start_o | output | 1 | One-cycle pulse in the first cycle of a conversion |
| conv_sel_o | output | 1 | Channel being converted (0 capacitive, 1 voltage/temperature) |
| single_done_o | output | 1 | Pulse when a single-shot sequence ends |
| cap_data_o | output | DATA_W | Capacitive data register |
| vt_data_o | output | DATA_W | Voltage/temperature data register |
| status_o | output | 8 | Status byte |
| rdy_n_o | output | 1 | Active-low combined ready pin |

## Verification
The bench measures start-to-start spacing for the longest and shortest rate settings and for random ones. An off-by-one in the prescaler or a missing doubling shows up directly as a wrong interval. It drives both channels through two rounds without reads: a combined flag that fell on the capacitive completion alone, or that never rose again before the next completion, is caught there. A read-busy window over a completion checks that the old data survives rather than being overwritten. The single-shot and abort cases catch a sequencer that keeps converting after its pulse, or that finishes a conversion after the mode was withdrawn.

// File: rtl/conv_seq_pkg.sv
// Shared types and conversion-time tables for the conversion sequencer.
// Assumes times are expressed in units of 0.1 ms; mode codes other than
// continuous and single are treated as "no conversion".
package conv_seq_pkg;

    localparam int UNIT_W = 13;

    localparam logic [2:0] MD_CONT   = 3'b001;
    localparam logic [2:0] MD_SINGLE = 3'b010;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef enum logic {
        CH_CAP = 1'b0,
        CH_VT  = 1'b1
    } chan_e;

    // Capacitive conversion time in 0.1 ms units, chopping in the top index bit.
    function automatic logic [UNIT_W-1:0] cap_units(input logic [2:0] code, input logic chop);
        logic [UNIT_W-1:0] u;
        case ({chop, code})
            4'h0: u = 13'd110;
            4'h1: u = 13'd119;
            4'h2: u = 13'd200;
            4'h3: u = 13'd380;
            4'h4: u = 13'd620;
            4'h5: u = 13'd770;
            4'h6: u = 13'd920;
            4'h7: u = 13'd1096;
            4'h8: u = 13'd201;
            4'h9: u = 13'd220;
            4'hA: u = 13'd381;
            4'hB: u = 13'd741;
            4'hC: u = 13'd1221;
            4'hD: u = 13'd1521;
            4'hE: u = 13'd1821;
            default: u = 13'd2173;
        endcase
        return u;
    endfunction

    // Voltage/temperature conversion time in 0.1 ms units.
    function automatic logic [UNIT_W-1:0] vt_units(input logic [1:0] code);
        logic [UNIT_W-1:0] u;
        case (code)
            2'd0:    u = 13'd201;
            2'd1:    u = 13'd321;
            2'd2:    u = 13'd621;
            default: u = 13'd1221;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/conv_timer.sv
// Conversion timer: a prescaler of TPU cycles per 0.1 ms tick feeding a
// down-counter of ticks. Assumes a load value of at least 1 and that load
// and abort never arrive together. expire_o is high in the final cycle.
module conv_timer #(
    parameter int TPU    = 100,
    parameter int UNIT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              abort_i,
    input  logic [UNIT_W-1:0] units_i,
    output logic              expire_o
);
    localparam int              PRE_W    = (TPU > 1) ? $clog2(TPU) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TPU - 1);

    logic              run_q;
    logic [PRE_W-1:0]  pre_q;
    logic [UNIT_W-1:0] units_q;

    assign expire_o = run_q && (pre_q == PRE_LAST) && (units_q == UNIT_W'(1));

    // Prescale clock cycles into ticks and count ticks down to expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pre_q   <= '0;
            units_q <= '0;
        end else if (abort_i) begin
            run_q <= 1'b0;
        end else if (load_i) begin
            run_q   <= 1'b1;
            pre_q   <= '0;
            units_q <= units_i;
        end else if (run_q) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (units_q == UNIT_W'(1)) run_q <= 1'b0;
                else                       units_q <= units_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R3: a new conversion is only loaded once the previous one has ended.
    a_r3_load_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !run_q);
    // R12: an abort leaves the timer stopped.
    a_r12_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !run_q);

endmodule

// File: rtl/conv_sched.sv
// Conversion scheduler: decides which channel converts next from the mode,
// the enables and the last channel, loads the timer with the duration and
// marks the completion cycle. Assumes the capacitive channel leads each round.
module conv_sched
    import conv_seq_pkg::*;
#(
    parameter int UNIT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              cap_en_i,
    input  logic              vt_en_i,
    input  logic [2:0]        cap_rate_i,
    input  logic              cap_chop_i,
    input  logic [1:0]        vt_rate_i,
    input  logic              clk_div_i,
    input  logic              expire_i,
    output logic              load_o,
    output logic              abort_o,
    output logic [UNIT_W-1:0] units_o,
    output logic              fin_o,
    output logic              sel_o,
    output logic              start_o,
    output logic              single_done_o
);
    seq_state_e        state_q;
    chan_e             cur_q;
    chan_e             nxt;
    logic              go;
    logic              close_single;
    logic              spent_q;
    logic              conv_mode;
    logic              allowed;
    logic [UNIT_W-1:0] base;

    assign conv_mode = (mode_i == MD_CONT) || (mode_i == MD_SINGLE);
    assign allowed   = (mode_i == MD_CONT) || ((mode_i == MD_SINGLE) && !spent_q);

    // Pick the next channel and whether a conversion starts this cycle.
    always_comb begin
        go           = 1'b0;
        nxt          = CH_CAP;
        close_single = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (allowed && (cap_en_i || vt_en_i)) begin
                    go  = 1'b1;
                    nxt = cap_en_i ? CH_CAP : CH_VT;
                end
            end
            ST_FIN: begin
                if (mode_i == MD_CONT) begin
                    if (cur_q == CH_CAP) begin
                        if (vt_en_i)       begin go = 1'b1; nxt = CH_VT;  end
                        else if (cap_en_i) begin go = 1'b1; nxt = CH_CAP; end
                    end else begin
                        if (cap_en_i)      begin go = 1'b1; nxt = CH_CAP; end
                        else if (vt_en_i)  begin go = 1'b1; nxt = CH_VT;  end
                    end
                end else if (mode_i == MD_SINGLE) begin
                    if ((cur_q == CH_CAP) && vt_en_i) begin
                        go  = 1'b1;
                        nxt = CH_VT;
                    end else begin
                        close_single = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // Duration of the chosen conversion, doubled when the clock is halved.
    always_comb begin
        base    = (nxt == CH_CAP) ? cap_units(cap_rate_i, cap_chop_i) : vt_units(vt_rate_i);
        units_o = clk_div_i ? {base[UNIT_W-2:0], 1'b0} : base;
    end

    assign load_o  = go;
    assign abort_o = (state_q == ST_RUN) && !conv_mode;
    assign fin_o   = (state_q == ST_FIN);
    assign sel_o   = cur_q;

    // Sequencer state, current channel and single-shot bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            cur_q         <= CH_CAP;
            spent_q       <= 1'b0;
            start_o       <= 1'b0;
            single_done_o <= 1'b0;
        end else begin
            start_o       <= go;
            single_done_o <= close_single;
            if (mode_i != MD_SINGLE)  spent_q <= 1'b0;
            else if (close_single)    spent_q <= 1'b1;
            case (state_q)
                ST_IDLE: if (go) begin state_q <= ST_RUN; cur_q <= nxt; end
                ST_RUN: begin
                    if (abort_o)       state_q <= ST_IDLE;
                    else if (expire_i) state_q <= ST_FIN;
                end
                default: begin
                    if (go) begin state_q <= ST_RUN; cur_q <= nxt; end
                    else          state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R5: every start strobe falls in the first cycle of a running conversion.
    a_r5_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (state_q == ST_RUN));
    // R2: a start only follows a cycle in a converting mode.
    a_r2_start_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(conv_mode));
    // R6: the single-shot pulse leaves the sequencer idle.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        single_done_o |-> (state_q == ST_IDLE));

endmodule

// File: rtl/conv_status.sv
// Result holding registers and status byte. Latches a completed result unless
// the host is reading that register, keeps per-channel and combined active-low
// ready flags. Assumes fin_i and expire_i are one-cycle marks from the scheduler.
module conv_status
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire_i,
    input  logic              fin_i,
    input  logic              sel_i,
    input  logic              cap_en_i,
    input  logic              vt_en_i,
    input  logic              exc_err_i,
    input  logic [DATA_W-1:0] cap_result_i,
    input  logic [DATA_W-1:0] vt_result_i,
    input  logic              cap_rd_busy_i,
    input  logic              vt_rd_busy_i,
    input  logic              cap_rd_done_i,
    input  logic              vt_rd_done_i,
    output logic [DATA_W-1:0] cap_data_o,
    output logic [DATA_W-1:0] vt_data_o,
    output logic [7:0]        status_o,
    output logic              rdy_n_o
);
    logic rdy_cap_q, rdy_vt_q, rdy_all_q;
    logic cap_take, vt_take, both_en, closer;

    assign cap_take = fin_i && (sel_i == CH_CAP) && !cap_rd_busy_i;
    assign vt_take  = fin_i && (sel_i == CH_VT)  && !vt_rd_busy_i;
    assign both_en  = cap_en_i && vt_en_i;
    assign closer   = both_en ? (vt_take && !rdy_cap_q) : (cap_take || vt_take);

    // Capacitive data register and its ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data_o <= '0;
            rdy_cap_q  <= 1'b1;
        end else if (expire_i && (sel_i == CH_CAP)) begin
            rdy_cap_q <= 1'b1;
        end else if (cap_take) begin
            cap_data_o <= cap_result_i;
            rdy_cap_q  <= 1'b0;
        end else if (cap_rd_done_i) begin
            rdy_cap_q <= 1'b1;
        end
    end

    // Voltage/temperature data register and its ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vt_data_o <= '0;
            rdy_vt_q  <= 1'b1;
        end else if (expire_i && (sel_i == CH_VT)) begin
            rdy_vt_q <= 1'b1;
        end else if (vt_take) begin
            vt_data_o <= vt_result_i;
            rdy_vt_q  <= 1'b0;
        end else if (vt_rd_done_i) begin
            rdy_vt_q <= 1'b1;
        end
    end

    // Combined ready flag: falls when the round's last enabled channel lands.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rdy_all_q <= 1'b1;
        else if (expire_i)                       rdy_all_q <= 1'b1;
        else if (closer)                         rdy_all_q <= 1'b0;
        else if (cap_rd_done_i || vt_rd_done_i)  rdy_all_q <= 1'b1;
    end

    assign status_o = {4'b0000, exc_err_i, rdy_all_q, rdy_vt_q, rdy_cap_q};
    assign rdy_n_o  = rdy_all_q;

    // R7: the capacitive flag only falls on a capacitive completion.
    a_r7_cap_fall_on_fin: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_cap_q) |-> $past(fin_i && (sel_i == CH_CAP)));
    // R10: a completion during a read keeps the held capacitive data.
    a_r10_busy_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && (sel_i == CH_CAP) && cap_rd_busy_i) |=> $stable(cap_data_o));
    // R8: with both channels on, the combined flag falls only with both fresh.
    a_r8_both_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (both_en && $fell(rdy_all_q)) |-> (!rdy_cap_q && !rdy_vt_q));

endmodule

// File: rtl/conv_sequencer.sv
// Top of the dual-channel conversion sequencer: scheduler, timer and status
// keeper. Assumes configuration inputs are stable while a conversion runs.
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int TPU    = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              cap_en_i,
    input  logic              vt_en_i,
    input  logic [2:0]        cap_rate_i,
    input  logic              cap_chop_i,
    input  logic [1:0]        vt_rate_i,
    input  logic              clk_div_i,
    input  logic              exc_err_i,
    input  logic [DATA_W-1:0] cap_result_i,
    input  logic [DATA_W-1:0] vt_result_i,
    input  logic              cap_rd_busy_i,
    input  logic              vt_rd_busy_i,
    input  logic              cap_rd_done_i,
    input  logic              vt_rd_done_i,
    output logic              conv_start_o,
    output logic              conv_sel_o,
    output logic              single_done_o,
    output logic [DATA_W-1:0] cap_data_o,
    output logic [DATA_W-1:0] vt_data_o,
    output logic [7:0]        status_o,
    output logic              rdy_n_o
);
    logic              load, abort, expire, fin;
    logic [UNIT_W-1:0] units;

    conv_sched #(.UNIT_W(UNIT_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .cap_en_i(cap_en_i), .vt_en_i(vt_en_i),
        .cap_rate_i(cap_rate_i), .cap_chop_i(cap_chop_i),
        .vt_rate_i(vt_rate_i), .clk_div_i(clk_div_i),
        .expire_i(expire), .load_o(load), .abort_o(abort),
        .units_o(units), .fin_o(fin), .sel_o(conv_sel_o),
        .start_o(conv_start_o), .single_done_o(single_done_o)
    );

    conv_timer #(.TPU(TPU), .UNIT_W(UNIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(load), .abort_i(abort),
        .units_i(units), .expire_o(expire)
    );

    conv_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .fin_i(fin),
        .sel_i(conv_sel_o), .cap_en_i(cap_en_i), .vt_en_i(vt_en_i),
        .exc_err_i(exc_err_i), .cap_result_i(cap_result_i),
        .vt_result_i(vt_result_i), .cap_rd_busy_i(cap_rd_busy_i),
        .vt_rd_busy_i(vt_rd_busy_i), .cap_rd_done_i(cap_rd_done_i),
        .vt_rd_done_i(vt_rd_done_i), .cap_data_o(cap_data_o),
        .vt_data_o(vt_data_o), .status_o(status_o), .rdy_n_o(rdy_n_o)
    );

endmodule

// File: tb/sim_conv_sequencer.sv
// Bench for conv_sequencer: random rate settings plus directed scenarios for
// ready flags, dropped results, single shot and abort.
module sim_conv_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int TPU        = 2;
    localparam int DW         = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    mode_i;
    logic          cap_en_i, vt_en_i, cap_chop_i, clk_div_i, exc_err_i;
    logic [2:0]    cap_rate_i;
    logic [1:0]    vt_rate_i;
    logic [DW-1:0] cap_result_i, vt_result_i;
    logic          cap_rd_busy_i, vt_rd_busy_i, cap_rd_done_i, vt_rd_done_i;
    logic          conv_start_o, conv_sel_o, single_done_o, rdy_n_o;
    logic [DW-1:0] cap_data_o, vt_data_o;
    logic [7:0]    status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_sequencer #(.DATA_W(DW), .TPU(TPU)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .cap_en_i(cap_en_i), .vt_en_i(vt_en_i), .cap_rate_i(cap_rate_i),
        .cap_chop_i(cap_chop_i), .vt_rate_i(vt_rate_i), .clk_div_i(clk_div_i),
        .exc_err_i(exc_err_i), .cap_result_i(cap_result_i), .vt_result_i(vt_result_i),
        .cap_rd_busy_i(cap_rd_busy_i), .vt_rd_busy_i(vt_rd_busy_i),
        .cap_rd_done_i(cap_rd_done_i), .vt_rd_done_i(vt_rd_done_i),
        .conv_start_o(conv_start_o), .conv_sel_o(conv_sel_o),
        .single_done_o(single_done_o), .cap_data_o(cap_data_o),
        .vt_data_o(vt_data_o), .status_o(status_o), .rdy_n_o(rdy_n_o)
    );

    function automatic int cap_time(input int code, input bit chop);
        int t_off[8] = '{110, 119, 200, 380, 620, 770, 920, 1096};
        int t_on[8]  = '{201, 220, 381, 741, 1221, 1521, 1821, 2173};
        return chop ? t_on[code] : t_off[code];
    endfunction

    function automatic int vt_time(input int code);
        int t[4] = '{201, 321, 621, 1221};
        return t[code];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start(output logic s);
        do @(negedge clk); while (!conv_start_o);
        s = conv_sel_o;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!conv_start_o);
    endtask

    task automatic pulse_rd(input bit c, input bit v);
        cap_rd_done_i = c;
        vt_rd_done_i  = v;
        @(negedge clk);
        cap_rd_done_i = 1'b0;
        vt_rd_done_i  = 1'b0;
    endtask

    task automatic count_starts(input int cycles, output int cnt, output int dones);
        cnt = 0; dones = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (conv_start_o) cnt++;
            if (single_done_o) dones++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic s;
        int   n, cnt, dones;
        void'($urandom(32'd4711));
        rst_n = 1'b0; mode_i = 3'b000; cap_en_i = 0; vt_en_i = 0;
        cap_rate_i = 0; cap_chop_i = 0; vt_rate_i = 0; clk_div_i = 0; exc_err_i = 0;
        cap_result_i = 24'h123456; vt_result_i = 24'h654321;
        cap_rd_busy_i = 0; vt_rd_busy_i = 0; cap_rd_done_i = 0; vt_rd_done_i = 0;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1: reset values
        check("R1 status", status_o, 8'h07);
        check("R1 rdy_n", rdy_n_o, 1);
        check("R1 data", cap_data_o | vt_data_o, 0);
        check("R1 start", conv_start_o, 0);

        // R2: non-converting modes start nothing
        cap_en_i = 1; vt_en_i = 1;
        foreach (n_modes[k]) begin
            mode_i = n_modes[k];
            count_starts(60, cnt, dones);
            check("R2 no start", cnt, 0);
        end
        mode_i = 3'b000;
        step(2);

        // R3 / R5: capacitive durations, corner settings then random
        for (int i = 0; i < 6; i++) begin
            int code; bit chop, dv;
            code = $urandom_range(7, 0); chop = 1'($urandom); dv = 1'($urandom);
            if (i == 0) begin code = 7; chop = 1; dv = 1; end
            if (i == 1) begin code = 0; chop = 0; dv = 0; end
            mode_i = 3'b000; step(3);
            cap_en_i = 1; vt_en_i = 0;
            cap_rate_i = 3'(code); cap_chop_i = chop; clk_div_i = dv;
            mode_i = 3'b001;
            wait_start(s);
            measure(n);
            check("R3 cap interval", n, cap_time(code, chop) * TPU * (dv ? 2 : 1) + 1);
            check("R5 single channel repeats", conv_sel_o, 0);
        end

        // R4: voltage/temperature durations
        for (int i = 0; i < 4; i++) begin
            bit dv;
            dv = 1'($urandom);
            mode_i = 3'b000; step(3);
            cap_en_i = 0; vt_en_i = 1; vt_rate_i = 2'(i); clk_div_i = dv;
            mode_i = 3'b001;
            wait_start(s);
            check("R4 vt select", s, 1);
            measure(n);
            check("R4 vt interval", n, vt_time(i) * TPU * (dv ? 2 : 1) + 1);
        end

        // R5 / R7 / R8 / R9 / R10 / R11: both channels continuous
        mode_i = 3'b000; step(3);
        cap_en_i = 1; vt_en_i = 1; cap_rate_i = 0; cap_chop_i = 0; vt_rate_i = 0; clk_div_i = 0;
        cap_result_i = 24'hA1A2A3; vt_result_i = 24'hB1B2B3;
        pulse_rd(1, 1);
        check("R9 read done raises", status_o[2:0], 3'b111);
        mode_i = 3'b001;
        wait_start(s);
        check("R5 first is cap", s, 0);
        wait_start(s);
        check("R5 then vt", s, 1);
        check("R7 cap data", cap_data_o, 24'hA1A2A3);
        check("R7 cap bit", status_o[0], 0);
        check("R8 waits for vt", rdy_n_o, 1);
        wait_start(s);
        check("R5 back to cap", s, 0);
        check("R7 vt data", vt_data_o, 24'hB1B2B3);
        check("R8 both done", status_o[2:0], 3'b000);
        check("R11 pin follows", rdy_n_o, status_o[2]);
        cap_rd_busy_i = 1; cap_result_i = 24'hC1C2C3;
        wait_start(s);
        check("R10 data kept", cap_data_o, 24'hA1A2A3);
        check("R10 bit stays 1", status_o[0], 1);
        check("R9 raised before completion", rdy_n_o, 1);
        cap_rd_busy_i = 0;
        wait_start(s);
        check("R8 stale cap blocks", rdy_n_o, 1);
        check("R7 vt bit", status_o[1], 0);
        pulse_rd(0, 1);
        check("R9 vt read done", status_o[1], 1);
        wait_start(s);
        check("R7 cap data new", cap_data_o, 24'hC1C2C3);
        check("R7 cap bit new", status_o[0], 0);
        check("R11 pin follows", rdy_n_o, status_o[2]);
        mode_i = 3'b000; step(3);

        // R8 single channel: combined mirrors capacitive bit
        vt_en_i = 0; pulse_rd(1, 1);
        mode_i = 3'b001;
        wait_start(s); wait_start(s);
        check("R8 mirrors cap", rdy_n_o, status_o[0]);
        check("R8 mirrors cap low", rdy_n_o, 0);

        // R12: abort mid-conversion
        mode_i = 3'b000; step(3);
        pulse_rd(1, 1);
        cap_result_i = 24'hE1E2E3;
        mode_i = 3'b001;
        wait_start(s);
        step(50);
        mode_i = 3'b000;
        count_starts(600, cnt, dones);
        check("R12 no restart", cnt, 0);
        check("R12 data unchanged", cap_data_o, 24'hC1C2C3);
        check("R12 bit unchanged", status_o[0], 1);

        // R6: single shot with both enabled, then vt only
        cap_en_i = 1; vt_en_i = 1;
        mode_i = 3'b010;
        wait_start(s);
        check("R6 cap first", s, 0);
        wait_start(s);
        check("R6 vt second", s, 1);
        count_starts(1300, cnt, dones);
        check("R6 no more starts", cnt, 0);
        check("R6 done pulse", dones, 1);
        mode_i = 3'b000; step(2);
        cap_en_i = 0;
        mode_i = 3'b010;
        wait_start(s);
        check("R6 vt only", s, 1);
        count_starts(800, cnt, dones);
        check("R6 vt only once", cnt, 0);
        check("R6 vt only done", dones, 1);
        mode_i = 3'b000; step(2);

        // R13: excitation error and unused bits
        exc_err_i = 1; step(1);
        check("R13 upper bits", status_o[7:3], 5'b00001);
        exc_err_i = 0; step(1);
        check("R13 error clears", status_o[3], 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    logic [2:0] n_modes [6] = '{3'b000, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};

endmodule